// File: doc/BRIEF.md
# Multi-Way Quasi-Sequential Stream Buffer

This block sits beside a data cache and holds several independent prefetch streams. Each stream is kept in a small queue of line entries. Each entry carries the line address it was requested for and, once the lower memory answers, that line's data. When the cache misses, the missing line address is offered to every stream in the same cycle. Each stream compares its three oldest entries, so a stream that hits on its second or third entry still hits. The entries in front of the match are dropped. This lets one or two lines be skipped without losing the stream.

A hit returns the line's data so the cache can be refilled. The winning stream then requests enough new successive lines to fill its queue again. A miss in every stream takes over the least recently used stream, which then restarts at the line after the missing one. Stores to the cache are also shown to the block, and any stream entry for the stored line is made unusable so stale data is never returned. All streams share one request port to lower memory, which they take in turn. Answers come back tagged with the stream index and the line address.

Top module: `qsb_multiway`

## Requirements
- R1: The result of a lookup appears exactly one cycle after the lookup is presented: rsp_valid_o high for that one cycle, with rsp_hit_o, rsp_way_o and rsp_data_o. With no lookup, rsp_valid_o is low.
- R2: A lookup that matches the oldest entry of a stream whose data has arrived is a hit. It returns that stream's index and the line data, and removes the entry from the stream.
- R3: A lookup that matches the second or third oldest entry is a hit. The one or two entries in front of the match are discarded, so a later lookup of a skipped line misses.
- R4: A line held only in the fourth or a later entry of a stream is not compared, and a lookup of it misses.
- R5: After a hit that removes n entries (the match plus the skipped ones), the stream issues n requests for successive lines. These continue from one above the last line it had requested, until it again holds 4 entries.
- R6: A lookup that hits in no stream takes over the victim stream. All of the victim's entries are dropped, and it requests the 4 lines that follow the missed line, in increasing order. Straight after reset, the victims of successive misses are streams 0, 1, 2 and 3 in that order.
- R7: The victim is the stream least recently hit or taken over. A hit or a takeover makes that stream the most recently used one.
- R8: When several streams hit the same lookup, the lowest stream index wins. The other streams keep their entries unchanged.
- R9: A store invalidates every entry holding the stored line, in every stream. A lookup of that line in the same cycle as the store misses. An invalidated entry never hits, and it stays in its queue position until a later hit removes it.
- R10: The shared request port grants the requesting streams round-robin. It starts after the stream granted last, so that two streams that both request are granted alternately.
- R11: After reset no stream is active: no request is issued and no response is produced until the first lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Cache miss lookup present |
| lk_line_i | input | 28 | Line address of the missing line |
| st_valid_i | input | 1 | Store to the cache present |
| st_line_i | input | 28 | Line address written by the store |
| rsp_valid_o | output | 1 | Lookup result valid |
| rsp_hit_o | output | 1 | Lookup hit in some stream |
| rsp_way_o | output | 2 | Index of the stream that hit |
| rsp_data_o | output | 128 | Line data on a hit |
| mem_req_valid_o | output | 1 | Line request to lower memory |
| mem_req_line_o | output | 28 | Requested line address |
| mem_req_way_o | output | 2 | Stream issuing the request |
| mem_req_ready_i | input | 1 | Lower memory accepts the request |
| mem_rsp_valid_i | input | 1 | Line data returning |
| mem_rsp_way_i | input | 2 | Stream the data belongs to |
| mem_rsp_line_i | input | 28 | Line address of the returning data |
| mem_rsp_data_i | input | 128 | Returning line data |

## Verification
A store and a lookup can reach the block in the same cycle, and the store must win. The bench drives a lookup and a store of the same line in one cycle, at a stream whose oldest entry holds that line. It expects a miss and a takeover of the current victim. Right after that, it looks up the next line. That line now sits behind the invalidated entry in the older stream and at the head of the newly taken stream. The bench expects the lower index to win, with the correct data, and that the dead entry was skipped.

// File: rtl/qsb_pkg.sv
package qsb_pkg;
  localparam int unsigned QSB_WAYS    = 4;
  localparam int unsigned QSB_DEPTH   = 4;
  localparam int unsigned QSB_CMP     = 3;
  localparam int unsigned QSB_LINE_AW = 28;
  localparam int unsigned QSB_DATA_W  = 128;
endpackage

// File: rtl/qsb_rr_arb.sv
module qsb_rr_arb #(
  parameter int unsigned N   = qsb_pkg::QSB_WAYS,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          ready_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] sel_o
);
  logic [IW-1:0] ptr_q;

  always_comb begin
    logic found;
    found = 1'b0;
    sel_o = ptr_q;
    for (int off = 1; off <= int'(N); off++) begin
      int idx;
      idx = (int'(ptr_q) + off) % int'(N);
      if (!found && req_i[idx]) begin
        found = 1'b1;
        sel_o = IW'(idx);
      end
    end
    gnt_o = '0;
    if (found && ready_i) gnt_o[sel_o] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= IW'(N - 1);
    else if (|gnt_o) ptr_q <= sel_o;
  end

  a_r10_gnt_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  a_r10_gnt_requested: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
endmodule

// File: rtl/qsb_lru.sv
module qsb_lru #(
  parameter int unsigned N   = qsb_pkg::QSB_WAYS,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          touch_i,
  input  logic [IW-1:0] touch_idx_i,
  output logic [IW-1:0] victim_o
);
  logic [IW-1:0] age_q [N];

  always_comb begin
    victim_o = '0;
    for (int i = 0; i < int'(N); i++)
      if (age_q[i] == IW'(N - 1)) victim_o = IW'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(N); i++) age_q[i] <= IW'(N - 1 - i);
    end else if (touch_i) begin
      for (int i = 0; i < int'(N); i++) begin
        if (i == int'(touch_idx_i)) age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx_i]) age_q[i] <= age_q[i] + IW'(1);
      end
    end
  end

  a_r7_touched_not_victim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |=> victim_o != $past(touch_idx_i));
endmodule

// File: rtl/qsb_way.sv
module qsb_way #(
  parameter int unsigned DEPTH   = qsb_pkg::QSB_DEPTH,
  parameter int unsigned CMP     = qsb_pkg::QSB_CMP,
  parameter int unsigned LINE_AW = qsb_pkg::QSB_LINE_AW,
  parameter int unsigned DATA_W  = qsb_pkg::QSB_DATA_W,
  localparam int unsigned SH_W   = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lk_valid_i,
  input  logic [LINE_AW-1:0] lk_line_i,
  input  logic               st_valid_i,
  input  logic [LINE_AW-1:0] st_line_i,
  output logic               hit_o,
  output logic [DATA_W-1:0]  hit_data_o,
  input  logic               consume_i,
  input  logic               flush_i,
  input  logic               fill_valid_i,
  input  logic [LINE_AW-1:0] fill_line_i,
  input  logic [DATA_W-1:0]  fill_data_i,
  input  logic               grant_i,
  output logic               req_o,
  output logic [LINE_AW-1:0] req_line_o
);
  logic [DEPTH-1:0]   occ_q, live_q, rdy_q;
  logic [LINE_AW-1:0] tag_q  [DEPTH];
  logic [DATA_W-1:0]  data_q [DEPTH];
  logic               act_q;
  logic [LINE_AW-1:0] nxt_q;

  logic [DEPTH-1:0]   occ_a, live_a, rdy_a, occ_d, live_d, rdy_d;
  logic [LINE_AW-1:0] tag_a  [DEPTH];
  logic [DATA_W-1:0]  data_a [DEPTH];
  logic [LINE_AW-1:0] tag_d  [DEPTH];
  logic [DATA_W-1:0]  data_d [DEPTH];
  logic               act_d;
  logic [LINE_AW-1:0] nxt_d;

  logic [CMP-1:0]  match;
  logic [SH_W-1:0] hit_pos;
  logic            st_kill;

  // a store to the looked-up line beats the lookup
  assign st_kill = st_valid_i && (st_line_i == lk_line_i);

  always_comb begin
    match   = '0;
    hit_pos = '0;
    for (int p = 0; p < int'(CMP); p++)
      match[p] = lk_valid_i && !st_kill && occ_q[p] && live_q[p] && rdy_q[p]
                 && (tag_q[p] == lk_line_i);
    for (int p = int'(CMP) - 1; p >= 0; p--)
      if (match[p]) hit_pos = SH_W'(p);
  end

  assign hit_o      = |match;
  assign hit_data_o = data_q[hit_pos];
  assign req_o      = act_q && !occ_q[DEPTH-1] && !flush_i;
  assign req_line_o = nxt_q;

  always_comb begin
    int cnt;
    int sh;
    occ_a = occ_q; live_a = live_q; rdy_a = rdy_q;
    tag_a = tag_q; data_a = data_q;
    act_d = act_q; nxt_d = nxt_q;
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (fill_valid_i && occ_a[i] && live_a[i] && !rdy_a[i] && tag_a[i] == fill_line_i) begin
        rdy_a[i]  = 1'b1;
        data_a[i] = fill_data_i;
      end
      if (st_valid_i && occ_a[i] && tag_a[i] == st_line_i) live_a[i] = 1'b0;
    end
    sh = consume_i ? int'(hit_pos) + 1 : 0;
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (!flush_i && (i + sh < int'(DEPTH))) begin
        occ_d[i]  = occ_a[i + sh];
        live_d[i] = live_a[i + sh];
        rdy_d[i]  = rdy_a[i + sh];
        tag_d[i]  = tag_a[i + sh];
        data_d[i] = data_a[i + sh];
      end else begin
        occ_d[i]  = 1'b0;
        live_d[i] = 1'b0;
        rdy_d[i]  = 1'b0;
        tag_d[i]  = '0;
        data_d[i] = '0;
      end
    end
    if (flush_i) begin
      act_d = 1'b1;
      nxt_d = lk_line_i + LINE_AW'(1);
    end
    cnt = 0;
    for (int i = 0; i < int'(DEPTH); i++) if (occ_d[i]) cnt++;
    if (grant_i) begin
      for (int i = 0; i < int'(DEPTH); i++) begin
        if (i == cnt) begin
          occ_d[i]  = 1'b1;
          live_d[i] = 1'b1;
          rdy_d[i]  = 1'b0;
          tag_d[i]  = nxt_q;
        end
      end
      nxt_d = nxt_q + LINE_AW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q  <= '0;
      live_q <= '0;
      rdy_q  <= '0;
      act_q  <= 1'b0;
      nxt_q  <= '0;
      for (int i = 0; i < int'(DEPTH); i++) begin
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else begin
      occ_q  <= occ_d;
      live_q <= live_d;
      rdy_q  <= rdy_d;
      act_q  <= act_d;
      nxt_q  <= nxt_d;
      tag_q  <= tag_d;
      data_q <= data_d;
    end
  end

  a_r8_consume_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consume_i |-> hit_o);
  a_r6_no_grant_on_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flush_i && grant_i));
  a_r5_next_line_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |=> nxt_q == $past(nxt_q) + LINE_AW'(1));
  a_r11_idle_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_q |-> !req_o);
endmodule

// File: rtl/qsb_multiway.sv
module qsb_multiway #(
  parameter int unsigned WAYS    = qsb_pkg::QSB_WAYS,
  parameter int unsigned DEPTH   = qsb_pkg::QSB_DEPTH,
  parameter int unsigned CMP     = qsb_pkg::QSB_CMP,
  parameter int unsigned LINE_AW = qsb_pkg::QSB_LINE_AW,
  parameter int unsigned DATA_W  = qsb_pkg::QSB_DATA_W,
  localparam int unsigned WW     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lk_valid_i,
  input  logic [LINE_AW-1:0] lk_line_i,
  input  logic               st_valid_i,
  input  logic [LINE_AW-1:0] st_line_i,
  output logic               rsp_valid_o,
  output logic               rsp_hit_o,
  output logic [WW-1:0]      rsp_way_o,
  output logic [DATA_W-1:0]  rsp_data_o,
  output logic               mem_req_valid_o,
  output logic [LINE_AW-1:0] mem_req_line_o,
  output logic [WW-1:0]      mem_req_way_o,
  input  logic               mem_req_ready_i,
  input  logic               mem_rsp_valid_i,
  input  logic [WW-1:0]      mem_rsp_way_i,
  input  logic [LINE_AW-1:0] mem_rsp_line_i,
  input  logic [DATA_W-1:0]  mem_rsp_data_i
);
  logic [WAYS-1:0]    hit_vec, consume, flush, req, gnt;
  logic [DATA_W-1:0]  hit_data [WAYS];
  logic [LINE_AW-1:0] req_line [WAYS];
  logic [WW-1:0]      win, victim, sel;
  logic               any_hit, all_miss;

  for (genvar w = 0; w < int'(WAYS); w++) begin : g_way
    qsb_way #(
      .DEPTH(DEPTH), .CMP(CMP), .LINE_AW(LINE_AW), .DATA_W(DATA_W)
    ) u_way (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .lk_valid_i   (lk_valid_i),
      .lk_line_i    (lk_line_i),
      .st_valid_i   (st_valid_i),
      .st_line_i    (st_line_i),
      .hit_o        (hit_vec[w]),
      .hit_data_o   (hit_data[w]),
      .consume_i    (consume[w]),
      .flush_i      (flush[w]),
      .fill_valid_i (mem_rsp_valid_i && (mem_rsp_way_i == WW'(w))),
      .fill_line_i  (mem_rsp_line_i),
      .fill_data_i  (mem_rsp_data_i),
      .grant_i      (gnt[w]),
      .req_o        (req[w]),
      .req_line_o   (req_line[w])
    );
  end

  // lowest index wins among simultaneous hits
  always_comb begin
    win = '0;
    for (int w = int'(WAYS) - 1; w >= 0; w--)
      if (hit_vec[w]) win = WW'(w);
  end

  assign any_hit  = |hit_vec;
  assign all_miss = lk_valid_i && !any_hit;

  always_comb begin
    consume = '0;
    flush   = '0;
    if (any_hit)  consume[win]  = 1'b1;
    if (all_miss) flush[victim] = 1'b1;
  end

  qsb_lru #(.N(WAYS)) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_i     (lk_valid_i),
    .touch_idx_i (any_hit ? win : victim),
    .victim_o    (victim)
  );

  qsb_rr_arb #(.N(WAYS)) u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req),
    .ready_i (mem_req_ready_i),
    .gnt_o   (gnt),
    .sel_o   (sel)
  );

  assign mem_req_valid_o = |req;
  assign mem_req_line_o  = req_line[sel];
  assign mem_req_way_o   = sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_way_o   <= '0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= lk_valid_i;
      rsp_hit_o   <= lk_valid_i && any_hit;
      rsp_way_o   <= win;
      rsp_data_o  <= hit_data[win];
    end
  end

  a_r1_rsp_follows_lookup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o == $past(lk_valid_i));
  a_r8_single_winner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(consume));
  a_r6_victim_missed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flush) |-> (hit_vec == '0));
  a_r1_hit_implies_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> rsp_valid_o);
endmodule

// File: tb/qsb_multiway_tb.sv
`timescale 1ns/1ps
module qsb_multiway_tb;
  localparam int LAT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic         lk_valid = 1'b0, st_valid = 1'b0, mem_ready = 1'b1;
  logic [27:0]  lk_line = '0, st_line = '0;
  logic         rsp_valid, rsp_hit, req_valid;
  logic [1:0]   rsp_way, req_way;
  logic [127:0] rsp_data;
  logic [27:0]  req_line;
  logic         m_valid;
  logic [1:0]   m_way;
  logic [27:0]  m_line;
  logic [127:0] m_data;

  qsb_multiway u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_valid), .lk_line_i(lk_line),
    .st_valid_i(st_valid), .st_line_i(st_line),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_way_o(rsp_way), .rsp_data_o(rsp_data),
    .mem_req_valid_o(req_valid), .mem_req_line_o(req_line), .mem_req_way_o(req_way),
    .mem_req_ready_i(mem_ready),
    .mem_rsp_valid_i(m_valid), .mem_rsp_way_i(m_way), .mem_rsp_line_i(m_line),
    .mem_rsp_data_i(m_data)
  );

  function automatic logic [127:0] dfn(input logic [27:0] ln);
    logic [31:0] x;
    x = {4'h0, ln};
    return {x, ~x, x ^ 32'h1234_5678, x + 32'd77};
  endfunction

  // pipelined responder
  logic        pv [LAT];
  logic [1:0]  pw [LAT];
  logic [27:0] pl [LAT];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) begin pv[i] <= 1'b0; pw[i] <= '0; pl[i] <= '0; end
    end else begin
      pv[0] <= req_valid && mem_ready;
      pw[0] <= req_way;
      pl[0] <= req_line;
      for (int i = 1; i < LAT; i++) begin pv[i] <= pv[i-1]; pw[i] <= pw[i-1]; pl[i] <= pl[i-1]; end
    end
  end
  assign m_valid = pv[LAT-1];
  assign m_way   = pw[LAT-1];
  assign m_line  = pl[LAT-1];
  assign m_data  = dfn(pl[LAT-1]);

  // request log
  logic [27:0] log_line [64];
  logic [1:0]  log_way  [64];
  int          log_n = 0;
  always @(posedge clk) begin
    if (rst_n && req_valid && mem_ready && log_n < 64) begin
      log_line[log_n] = req_line;
      log_way[log_n]  = req_way;
      log_n = log_n + 1;
    end
  end

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic lookup(input logic [27:0] ln, input bit with_store, input bit exp_hit,
                        input logic [1:0] exp_way, input string rq);
    @(negedge clk);
    lk_valid = 1'b1; lk_line = ln;
    st_valid = with_store; st_line = ln;
    @(negedge clk);
    lk_valid = 1'b0; st_valid = 1'b0;
    chk(rsp_valid == 1'b1, {rq, " R1 rsp_valid"}, 128'(rsp_valid), 128'(1));
    chk(rsp_hit == exp_hit, {rq, " hit flag"}, 128'(rsp_hit), 128'(exp_hit));
    if (exp_hit) begin
      chk(rsp_way == exp_way, {rq, " way"}, 128'(rsp_way), 128'(exp_way));
      chk(rsp_data == dfn(ln), {rq, " data"}, rsp_data, dfn(ln));
    end
    @(negedge clk);
    chk(rsp_valid == 1'b0, {rq, " R1 single pulse"}, 128'(rsp_valid), 128'(0));
  endtask

  task automatic store(input logic [27:0] ln);
    @(negedge clk);
    st_valid = 1'b1; st_line = ln;
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic exp_reqs(input int base, input logic [1:0] w, input logic [27:0] first,
                          input int n, input string rq);
    idle(20);
    chk(log_n == base + n, {rq, " request count"}, 128'(log_n), 128'(base + n));
    for (int k = 0; k < n; k++) begin
      chk(log_way[base+k] == w, {rq, " request way"}, 128'(log_way[base+k]), 128'(w));
      chk(log_line[base+k] == first + 28'(k), {rq, " request line"},
          128'(log_line[base+k]), 128'(first + 28'(k)));
    end
  endtask

  task automatic t_reset;
    idle(5);
    chk(rsp_valid == 1'b0, "R11 no response", 128'(rsp_valid), 128'(0));
    chk(req_valid == 1'b0, "R11 no request", 128'(req_valid), 128'(0));
    chk(log_n == 0, "R11 no accepted request", 128'(log_n), 128'(0));
  endtask

  task automatic t_alloc;
    lookup(28'd100, 1'b0, 1'b0, 2'd0, "R6 first miss");
    exp_reqs(0, 2'd0, 28'd101, 4, "R6 way0 prefetch");
  endtask

  task automatic t_head;
    lookup(28'd101, 1'b0, 1'b1, 2'd0, "R2 head hit");
    exp_reqs(4, 2'd0, 28'd105, 1, "R5 one refill");
  endtask

  task automatic t_skip;
    lookup(28'd104, 1'b0, 1'b1, 2'd0, "R3 skip two");
    exp_reqs(5, 2'd0, 28'd106, 3, "R5 three refills");
  endtask

  task automatic t_deep;
    lookup(28'd108, 1'b0, 1'b0, 2'd0, "R4 fourth entry not compared");
    exp_reqs(8, 2'd1, 28'd109, 4, "R6 second victim way1");
  endtask

  task automatic t_discard;
    lookup(28'd103, 1'b0, 1'b0, 2'd0, "R3 skipped line gone");
    exp_reqs(12, 2'd2, 28'd104, 4, "R6 third victim way2");
  endtask

  task automatic t_prio;
    lookup(28'd106, 1'b0, 1'b1, 2'd0, "R8 lowest way wins");
    exp_reqs(16, 2'd0, 28'd109, 2, "R5 two refills");
    lookup(28'd106, 1'b0, 1'b1, 2'd2, "R8 loser kept line");
    exp_reqs(18, 2'd2, 28'd108, 3, "R5 loser refills");
  endtask

  task automatic t_lru;
    lookup(28'd500, 1'b0, 1'b0, 2'd0, "R6 miss to way3");
    exp_reqs(21, 2'd3, 28'd501, 4, "R6 way3 prefetch");
    lookup(28'd600, 1'b0, 1'b0, 2'd0, "R7 miss to lru");
    exp_reqs(25, 2'd1, 28'd601, 4, "R7 victim is least recent way1");
  endtask

  task automatic t_store;
    store(28'd108);
    lookup(28'd108, 1'b0, 1'b0, 2'd0, "R9 invalidated in way0 and way2");
    exp_reqs(29, 2'd0, 28'd109, 4, "R9 victim way0");
    lookup(28'd108, 1'b0, 1'b0, 2'd0, "R9 way2 copy dead");
    exp_reqs(33, 2'd2, 28'd109, 4, "R9 victim way2");
  endtask

  task automatic t_same_cycle;
    lookup(28'd601, 1'b1, 1'b0, 2'd0, "R9 store beats lookup");
    exp_reqs(37, 2'd3, 28'd602, 4, "R9 victim way3");
    lookup(28'd602, 1'b0, 1'b1, 2'd1, "R9 dead head skipped");
    exp_reqs(41, 2'd1, 28'd605, 2, "R5 refill past dead entry");
  endtask

  task automatic t_rr;
    @(negedge clk);
    mem_ready = 1'b0;
    lookup(28'd700, 1'b0, 1'b0, 2'd0, "R10 miss to way0");
    lookup(28'd800, 1'b0, 1'b0, 2'd0, "R10 miss to way2");
    @(negedge clk);
    mem_ready = 1'b1;
    idle(20);
    chk(log_n == 51, "R10 request count", 128'(log_n), 128'(51));
    for (int k = 0; k < 8; k++) begin
      logic [1:0]  ew;
      logic [27:0] el;
      ew = (k % 2 == 0) ? 2'd2 : 2'd0;
      el = ((k % 2 == 0) ? 28'd801 : 28'd701) + 28'(k / 2);
      chk(log_way[43+k] == ew, "R10 alternating way", 128'(log_way[43+k]), 128'(ew));
      chk(log_line[43+k] == el, "R10 line order", 128'(log_line[43+k]), 128'(el));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_alloc();
    t_head();
    t_skip();
    t_deep();
    t_discard();
    idle(10);
    t_prio();
    t_lru();
    t_store();
    t_same_cycle();
    idle(20);
    t_rr();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule